// File: doc/BRIEF.md
# Rotating Per-Task Register Context Bank

This block holds the programmer-visible register state of a small 8-bit processor for several tasks at the same time. Each register (accumulator, index, condition codes, stack pointer and a 12-bit program counter) is kept as a ring of copies, one copy per task. The processor always reads and writes the copy at the head of the ring, so its register datapath behaves the same whichever task is running.

A scheduler selects a task by driving its index on the target input. The bank then rotates every ring forward by one slot per clock until the wanted task's copy reaches the head. The switch therefore takes as many cycles as the forward distance from the current task to the target, wrapping past the last task. While the rotation runs, the busy output is high. The processor must stall, and register writes are dropped so that no task's context is corrupted.

Top module: `ctx_rotor_bank`

## Requirements
- R1: After synchronous reset the current task is 0. Every accumulator, index, condition-code and program-counter copy is zero. Every stack-pointer copy equals the parameter SP_INIT, whose default is 5'h1F.
- R2: The outputs acc_q (8 bits), idx_q (8 bits), ccr_q (5 bits), sp_q (5 bits) and pc_q (12 bits) always show the copies that belong to the task index on cur_task.
- R3: When busy is low, each register whose write enable is high takes its write data at the clock edge, and the new value is visible on its output in the following cycle. Registers without an enable, and all other tasks' copies, keep their values.
- R4: While busy is high, cur_task advances by exactly one per clock, always upward, and never leaves the range 0 to NUM_TASKS-1.
- R5: busy is high exactly when target_task is below NUM_TASKS and differs from cur_task. A switch from task a to task b keeps busy high for (b - a) mod NUM_TASKS cycles.
- R6: Write enables have no effect on any task's copy during a cycle in which busy is high.
- R7: The values a task holds when it leaves the head are shown again, unchanged, when it returns to the head.
- R8: A target_task value of NUM_TASKS or more is ignored: busy stays low, cur_task does not move, and writes proceed as in R3.
- R9: From task NUM_TASKS-1 the next rotation step reaches task 0 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| target_task | input | TID_W | Task index requested by the scheduler |
| busy | output | 1 | High while the ring is rotating; the processor stalls |
| cur_task | output | TID_W | Index of the task whose copies are at the head |
| acc_we | input | 1 | Accumulator write enable |
| acc_wd | input | 8 | Accumulator write data |
| idx_we | input | 1 | Index register write enable |
| idx_wd | input | 8 | Index register write data |
| ccr_we | input | 1 | Condition-code write enable |
| ccr_wd | input | 5 | Condition-code write data |
| sp_we | input | 1 | Stack pointer write enable |
| sp_wd | input | 5 | Stack pointer write data |
| pc_we | input | 1 | Program counter write enable |
| pc_wd | input | 12 | Program counter write data |
| acc_q | output | 8 | Accumulator of the current task |
| idx_q | output | 8 | Index register of the current task |
| ccr_q | output | 5 | Condition codes of the current task |
| sp_q | output | 5 | Stack pointer of the current task |
| pc_q | output | 12 | Program counter of the current task |

## Verification
The hardest condition to reach from the ports is a write request that lands in the middle of a long rotation, where a leak would corrupt a context that is not at the head. The corruption would only show later, when that task comes back around. The stimulus holds all write enables high with fresh data through full-distance switches, including the wrap from the last task to task 0. It then rotates back to every task and compares each head against a bench model. The model applies writes only in idle cycles. Random stretches mix targets, out-of-range targets and write bursts, and the outputs are compared with the model every cycle.

// File: rtl/ctx_bank_pkg.sv
package ctx_bank_pkg;

    localparam int ACC_W = 8;
    localparam int IDX_W = 8;
    localparam int CCR_W = 5;
    localparam int SP_W  = 5;
    localparam int PC_W  = 12;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [SP_W-1:0]  sp;
        logic [CCR_W-1:0] ccr;
        logic [IDX_W-1:0] idx;
        logic [ACC_W-1:0] acc;
    } ctx_t;

    typedef struct packed {
        logic pc;
        logic sp;
        logic ccr;
        logic idx;
        logic acc;
    } ctx_we_t;

    localparam int CTX_W = $bits(ctx_t);

    function automatic int tid_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // slot that feeds slot pos when the ring advances one step
    function automatic int ring_src(input int pos, input int n);
        return (pos + 1 >= n) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/ctx_ring.sv
module ctx_ring #(
    parameter int         WIDTH   = 8,
    parameter int         DEPTH   = 7,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] head
);
    import ctx_bank_pkg::*;

    logic [WIDTH-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam int SRC = ring_src(i, DEPTH);
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)
                    slot[i] <= RST_VAL;
                else if (shift)
                    slot[i] <= slot[SRC];
                else if (wr_en)
                    slot[i] <= wr_data;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)
                    slot[i] <= RST_VAL;
                else if (shift)
                    slot[i] <= slot[SRC];
            end
        end
    end

    assign head = slot[0];

endmodule

// File: rtl/ctx_task_seq.sv
module ctx_task_seq #(
    parameter int NUM_TASKS = 7,
    parameter int TID_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TID_W-1:0] target,
    output logic [TID_W-1:0] cur,
    output logic             advance
);
    localparam logic [TID_W:0]   N_EXT = (TID_W+1)'(NUM_TASKS);
    localparam logic [TID_W-1:0] LAST  = (TID_W)'(NUM_TASKS - 1);

    logic target_ok;

    assign target_ok = ({1'b0, target} < N_EXT);
    assign advance   = target_ok && (target != cur);

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (advance)
            cur <= (cur == LAST) ? '0 : cur + 1'b1;
    end

endmodule

// File: rtl/ctx_write_gate.sv
module ctx_write_gate (
    input  logic                  hold,
    input  ctx_bank_pkg::ctx_we_t req,
    output ctx_bank_pkg::ctx_we_t grant
);
    always_comb begin
        grant = req;
        if (hold)
            grant = '0;
    end
endmodule

// File: rtl/ctx_rotor_bank.sv
module ctx_rotor_bank #(
    parameter int         NUM_TASKS = 7,
    parameter logic [4:0] SP_INIT   = 5'h1F,
    localparam int        TID_W     = ctx_bank_pkg::tid_width(NUM_TASKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TID_W-1:0] target_task,
    output logic             busy,
    output logic [TID_W-1:0] cur_task,
    input  logic             acc_we,
    input  logic [7:0]       acc_wd,
    input  logic             idx_we,
    input  logic [7:0]       idx_wd,
    input  logic             ccr_we,
    input  logic [4:0]       ccr_wd,
    input  logic             sp_we,
    input  logic [4:0]       sp_wd,
    input  logic             pc_we,
    input  logic [11:0]      pc_wd,
    output logic [7:0]       acc_q,
    output logic [7:0]       idx_q,
    output logic [4:0]       ccr_q,
    output logic [4:0]       sp_q,
    output logic [11:0]      pc_q
);
    import ctx_bank_pkg::*;

    ctx_t    wr_ctx;
    ctx_t    head_ctx;
    ctx_we_t we_req;
    ctx_we_t we_ok;
    logic    rotate;

    assign wr_ctx = '{pc: pc_wd, sp: sp_wd, ccr: ccr_wd, idx: idx_wd, acc: acc_wd};
    assign we_req = '{pc: pc_we, sp: sp_we, ccr: ccr_we, idx: idx_we, acc: acc_we};

    ctx_task_seq #(.NUM_TASKS(NUM_TASKS), .TID_W(TID_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .target  (target_task),
        .cur     (cur_task),
        .advance (rotate)
    );

    ctx_write_gate u_gate (
        .hold  (rotate),
        .req   (we_req),
        .grant (we_ok)
    );

    ctx_ring #(.WIDTH(ACC_W), .DEPTH(NUM_TASKS), .RST_VAL('0)) u_acc (
        .clk(clk), .rst(rst), .shift(rotate), .wr_en(we_ok.acc),
        .wr_data(wr_ctx.acc), .head(head_ctx.acc));

    ctx_ring #(.WIDTH(IDX_W), .DEPTH(NUM_TASKS), .RST_VAL('0)) u_idx (
        .clk(clk), .rst(rst), .shift(rotate), .wr_en(we_ok.idx),
        .wr_data(wr_ctx.idx), .head(head_ctx.idx));

    ctx_ring #(.WIDTH(CCR_W), .DEPTH(NUM_TASKS), .RST_VAL('0)) u_ccr (
        .clk(clk), .rst(rst), .shift(rotate), .wr_en(we_ok.ccr),
        .wr_data(wr_ctx.ccr), .head(head_ctx.ccr));

    ctx_ring #(.WIDTH(SP_W), .DEPTH(NUM_TASKS), .RST_VAL(SP_INIT)) u_sp (
        .clk(clk), .rst(rst), .shift(rotate), .wr_en(we_ok.sp),
        .wr_data(wr_ctx.sp), .head(head_ctx.sp));

    ctx_ring #(.WIDTH(PC_W), .DEPTH(NUM_TASKS), .RST_VAL('0)) u_pc (
        .clk(clk), .rst(rst), .shift(rotate), .wr_en(we_ok.pc),
        .wr_data(wr_ctx.pc), .head(head_ctx.pc));

    assign busy  = rotate;
    assign acc_q = head_ctx.acc;
    assign idx_q = head_ctx.idx;
    assign ccr_q = head_ctx.ccr;
    assign sp_q  = head_ctx.sp;
    assign pc_q  = head_ctx.pc;

endmodule

// File: rtl/ctx_rotor_bank_chk.sv
module ctx_rotor_bank_chk #(
    parameter int NUM_TASKS = 7,
    parameter int TID_W     = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [TID_W-1:0] cur_task,
    input logic             acc_we,
    input logic [7:0]       acc_wd,
    input logic [7:0]       acc_q,
    input logic             pc_we,
    input logic [11:0]      pc_wd,
    input logic [11:0]      pc_q
);
    localparam logic [TID_W-1:0] LAST = (TID_W)'(NUM_TASKS - 1);

    // R1
    reset_exit_chk: assert property (@(posedge clk) $fell(rst) |-> cur_task == '0);

    // R4
    advance_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> cur_task == (($past(cur_task) == LAST) ? '0 : $past(cur_task) + 1'b1));

    // R4
    index_range_chk: assert property (@(posedge clk) disable iff (rst) cur_task <= LAST);

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_task == LAST) |=> cur_task == '0);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(cur_task));

    // R3
    acc_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && acc_we) |=> acc_q == $past(acc_wd));

    // R3
    pc_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && pc_we) |=> pc_q == $past(pc_wd));

    // R3
    pc_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !pc_we) |=> $stable(pc_q));

endmodule

bind ctx_rotor_bank ctx_rotor_bank_chk #(.NUM_TASKS(NUM_TASKS), .TID_W(TID_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .cur_task(cur_task),
    .acc_we(acc_we), .acc_wd(acc_wd), .acc_q(acc_q),
    .pc_we(pc_we), .pc_wd(pc_wd), .pc_q(pc_q)
);

// File: tb/ctx_rotor_bank_test.sv
module ctx_rotor_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT    = 7;
    localparam int TW    = 3;
    localparam logic [4:0] SPI = 5'h1F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] target_task = '0;
    logic          busy;
    logic [TW-1:0] cur_task;
    logic          acc_we = 0, idx_we = 0, ccr_we = 0, sp_we = 0, pc_we = 0;
    logic [7:0]    acc_wd = 0, idx_wd = 0;
    logic [4:0]    ccr_wd = 0, sp_wd = 0;
    logic [11:0]   pc_wd = 0;
    logic [7:0]    acc_q, idx_q;
    logic [4:0]    ccr_q, sp_q;
    logic [11:0]   pc_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of every task's context
    logic [7:0]  m_acc [NT];
    logic [7:0]  m_idx [NT];
    logic [4:0]  m_ccr [NT];
    logic [4:0]  m_sp  [NT];
    logic [11:0] m_pc  [NT];
    int          m_cur;

    ctx_rotor_bank #(.NUM_TASKS(NT), .SP_INIT(SPI)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit exp_busy();
        return (int'(target_task) < NT) && (int'(target_task) != m_cur);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R5 busy"}, int'(busy), int'(exp_busy()));
        chk({tag, " R4 cur_task"}, int'(cur_task), m_cur);
        chk({tag, " R2 acc"}, int'(acc_q), int'(m_acc[m_cur]));
        chk({tag, " R2 idx"}, int'(idx_q), int'(m_idx[m_cur]));
        chk({tag, " R2 ccr"}, int'(ccr_q), int'(m_ccr[m_cur]));
        chk({tag, " R2 sp"}, int'(sp_q), int'(m_sp[m_cur]));
        chk({tag, " R2 pc"}, int'(pc_q), int'(m_pc[m_cur]));
    endtask

    task automatic model_edge();
        if (exp_busy())
            m_cur = (m_cur + 1) % NT;  // R6: writes dropped while rotating
        else begin
            if (acc_we) m_acc[m_cur] = acc_wd;
            if (idx_we) m_idx[m_cur] = idx_wd;
            if (ccr_we) m_ccr[m_cur] = ccr_wd;
            if (sp_we)  m_sp[m_cur]  = sp_wd;
            if (pc_we)  m_pc[m_cur]  = pc_wd;
        end
    endtask

    // called just after a falling edge with inputs already set
    task automatic step(input string tag);
        #1;
        compare_all(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic set_writes(input logic [4:0] mask);
        {pc_we, sp_we, ccr_we, idx_we, acc_we} = mask;
        acc_wd = 8'($urandom);
        idx_wd = 8'($urandom);
        ccr_wd = 5'($urandom);
        sp_wd  = 5'($urandom);
        pc_wd  = 12'($urandom);
    endtask

    // R5: count busy cycles of a switch and compare with the ring distance
    task automatic switch_to(input int t, input logic [4:0] mask, input string tag);
        int expd;
        int cnt;
        expd = (t - m_cur + NT) % NT;
        cnt = 0;
        target_task = TW'(t);
        for (int g = 0; g < 3 * NT; g++) begin
            set_writes(mask);
            #1;
            if (!busy) break;
            cnt++;
            step(tag);
        end
        set_writes(5'b0);
        chk({tag, " R5 latency"}, cnt, expd);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NT; i++) begin
            m_acc[i] = 0; m_idx[i] = 0; m_ccr[i] = 0; m_sp[i] = SPI; m_pc[i] = 0;
        end
        m_cur = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset contents of the head, then every task by rotation
        step("R1 reset head");
        switch_to(NT - 1, 5'b0, "R1 sweep");
        step("R1 last task");
        // R9: wrap to 0 takes one cycle
        switch_to(0, 5'b0, "R9 wrap");
        step("R9 after wrap");

        // R3: individual writes to task 0
        set_writes(5'b00001); step("R3 acc write");
        set_writes(5'b10000); step("R3 pc write");
        set_writes(5'b01110); step("R3 idx ccr sp write");
        set_writes(5'b0);     step("R3 hold");

        // R7: leave, modify another task, come back
        switch_to(3, 5'b0, "R7 go3");
        set_writes(5'b11111); step("R7 write t3");
        set_writes(5'b0);
        switch_to(0, 5'b0, "R7 back0");
        step("R7 t0 kept");
        switch_to(3, 5'b0, "R7 go3 again");
        step("R7 t3 kept");

        // R6: all enables high during full-distance rotations
        switch_to(2, 5'b11111, "R6 busy writes");
        switch_to(1, 5'b11111, "R6 busy writes wrap");
        for (int t = 0; t < NT; t++) begin
            switch_to((1 + t + 1) % NT, 5'b0, "R6 sweep");
            step("R6 context intact");
        end

        // R8: out-of-range target ignored, writes still accepted
        target_task = TW'(NT);
        set_writes(5'b11111); step("R8 invalid target write");
        set_writes(5'b0);     step("R8 invalid target hold");
        chk("R8 cur unchanged", int'(cur_task), m_cur);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 7) == 0)
                target_task = TW'($urandom_range(0, (1 << TW) - 1));
            set_writes(5'($urandom));
            step("RND");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule